// File: doc/BRIEF.md
# Floating-Point Exception Cause and Trap Controller

This block sits beside a floating-point arithmetic datapath and decides what happens to each operation's result. The datapath asserts a one-cycle start strobe together with its raw status flags: invalid operation, finite divide by zero, overflow, underflow, denormal result, inexact and rounded. The block combines these flags with five software-programmed enable bits and does three things. It records which exception cause was taken, it decides whether the destination register may be written (and whether a quiet NaN must be written in place of the computed value), and it raises a trap request carrying a fixed trap code.

Every operation starts from a clean cause field. Invalid and divide-by-zero are handled first. Overflow, underflow and inexact then form a fixed priority chain, so at most one cause is ever recorded. Any recorded cause blocks the destination write. Software reads and writes the enable and cause fields through a single control word.

Top module: `fpx_trap_unit`

## Requirements
- R1: After reset, the enable field and the cause field are zero, and opDone, resultWrEn, qnanSel and trapReq are low.
- R2: The control word holds the enables in bits [4:0] and the causes in bits [12:8], with the same bit order in both fields: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero, bit 4 invalid. A write with regWrEn loads both fields, and regRdData shows them with all other bits zero.
- R3: A start strobe replaces the whole cause field with the cause of that operation, so causes left by earlier operations or writes are cleared. opDone, resultWrEn, qnanSel and trapReq are one-cycle pulses in the cycle after the start.
- R4: Invalid (opFlags bit 6) with the invalid enable set records only the invalid cause and suppresses the write, whatever the other flags are.
- R5: Invalid with the invalid enable clear records no cause and writes a quiet NaN (resultWrEn and qnanSel both high), whatever the other flags are.
- R6: If the operation is not invalid, a finite divide by zero (opFlags bit 5) with the divide enable set records only the divide cause and suppresses the write.
- R7: If neither of the above applies, overflow (opFlags bit 4) with the overflow enable set records only the overflow cause, even when underflow or inexact flags are also present.
- R8: If overflow is not taken, underflow (bit 3) or denormal (bit 2) with the underflow enable set records only the underflow cause.
- R9: If neither overflow nor underflow is taken, inexact (bit 1) or rounded (bit 0) with the inexact enable set records only the inexact cause.
- R10: A flag whose enable is clear produces no cause. If no cause results, the computed value is written (resultWrEn high, qnanSel low).
- R11: trapReq pulses with opDone exactly when the operation recorded a cause, and trapCode then reads 0x1d0. An operation with no cause raises no trap.
- R12: When a start and a register write fall in the same cycle, the operation is decided with the old enables, the new enables come from the write, and the cause field takes the operation's result, not the written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opStart | input | 1 | One-cycle strobe marking an operation's status flags as valid |
| opFlags | input | 7 | Raw datapath status: 6 invalid, 5 divide by zero, 4 overflow, 3 underflow, 2 denormal, 1 inexact, 0 rounded |
| regWrEn | input | 1 | Software write strobe for the control word |
| regWrData | input | 16 | Control word to write |
| regRdData | output | 16 | Current control word |
| causeOut | output | 5 | Current cause field |
| opDone | output | 1 | Pulse marking the decision for the last start |
| resultWrEn | output | 1 | Destination register may be written |
| qnanSel | output | 1 | Written value must be the quiet NaN |
| trapReq | output | 1 | Trap request pulse |
| trapCode | output | 12 | Trap code, 0x1d0 while trapReq is high |

## Verification
A wrong cause register shows up at causeOut and regRdData in the cycle after the start that set it. It also shows as a mismatched resultWrEn or trapReq in that same pulse. A lost priority or a stale cause from an earlier operation therefore appears one clock after the offending operation. A corrupted enable register does not show on its own at the output pulses. It shows on regRdData at once, and it reaches the trap decisions only when a later operation carries the flag it governs. For that reason the bench compares the read-back word on every clock and sends each flag through with its enable both set and clear.

// File: rtl/fpx_trap_pkg.sv
package fpx_trap_pkg;
  localparam int NUM_CAUSE = 5;
  localparam int NUM_FLAG  = 7;

  // cause / enable bit positions (shared by both fields)
  localparam int CZ_INEXACT  = 0;
  localparam int CZ_UNDER    = 1;
  localparam int CZ_OVER     = 2;
  localparam int CZ_DIVZERO  = 3;
  localparam int CZ_INVALID  = 4;

  // raw flag positions
  localparam int FL_ROUNDED  = 0;
  localparam int FL_INEXACT  = 1;
  localparam int FL_DENORM   = 2;
  localparam int FL_UNDER    = 3;
  localparam int FL_OVER     = 4;
  localparam int FL_DIVZERO  = 5;
  localparam int FL_INVALID  = 6;

  typedef logic [NUM_CAUSE-1:0] causeVec_t;

  typedef struct packed {
    logic      opDone;
    logic      swWrite;
    logic      writeResult;
    logic      selQnan;
    causeVec_t newCause;
  } fpxStrobes_t;
endpackage

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
  import fpx_trap_pkg::*;
(
  input  logic                opStart,
  input  logic [NUM_FLAG-1:0] opFlags,
  input  logic                regWrEn,
  input  causeVec_t           enables,
  output fpxStrobes_t         strobes
);
  causeVec_t cause;
  logic      invalidOp;

  assign invalidOp = opFlags[FL_INVALID];

  // Decision chain: invalid, divide, then overflow > underflow > inexact.
  always_comb begin
    cause = '0;
    if (invalidOp) begin
      if (enables[CZ_INVALID]) cause[CZ_INVALID] = 1'b1;
    end else if (opFlags[FL_DIVZERO] && enables[CZ_DIVZERO]) begin
      cause[CZ_DIVZERO] = 1'b1;
    end else if (opFlags[FL_OVER] && enables[CZ_OVER]) begin
      cause[CZ_OVER] = 1'b1;
    end else if ((opFlags[FL_UNDER] || opFlags[FL_DENORM]) && enables[CZ_UNDER]) begin
      cause[CZ_UNDER] = 1'b1;
    end else if ((opFlags[FL_INEXACT] || opFlags[FL_ROUNDED]) && enables[CZ_INEXACT]) begin
      cause[CZ_INEXACT] = 1'b1;
    end
  end

  always_comb begin
    strobes.opDone      = opStart;
    strobes.swWrite     = regWrEn;
    strobes.newCause    = cause;
    strobes.writeResult = (cause == '0);
    strobes.selQnan     = invalidOp && !enables[CZ_INVALID];
  end
endmodule

// File: rtl/fpx_trap_datapath.sv
module fpx_trap_datapath
  import fpx_trap_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int EN_LSB    = 0,
  parameter int CAUSE_LSB = 8,
  parameter int CODE_W    = 12,
  parameter logic [CODE_W-1:0] TRAP_CODE = 12'h1d0
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpxStrobes_t       strobes,
  input  logic [DATA_W-1:0] regWrData,
  output causeVec_t         enables,
  output causeVec_t         causeQ,
  output logic [DATA_W-1:0] regRdData,
  output logic              opDone,
  output logic              resultWrEn,
  output logic              qnanSel,
  output logic              trapReq,
  output logic [CODE_W-1:0] trapCode
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enables    <= '0;
      causeQ     <= '0;
      opDone     <= 1'b0;
      resultWrEn <= 1'b0;
      qnanSel    <= 1'b0;
      trapReq    <= 1'b0;
    end else begin
      if (strobes.swWrite) enables <= regWrData[EN_LSB +: NUM_CAUSE];
      if (strobes.opDone)
        causeQ <= strobes.newCause;
      else if (strobes.swWrite)
        causeQ <= regWrData[CAUSE_LSB +: NUM_CAUSE];
      opDone     <= strobes.opDone;
      resultWrEn <= strobes.opDone && strobes.writeResult;
      qnanSel    <= strobes.opDone && strobes.selQnan;
      trapReq    <= strobes.opDone && (strobes.newCause != '0);
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[EN_LSB +: NUM_CAUSE]    = enables;
    regRdData[CAUSE_LSB +: NUM_CAUSE] = causeQ;
  end

  assign trapCode = trapReq ? TRAP_CODE : '0;
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit
  import fpx_trap_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int EN_LSB    = 0,
  parameter int CAUSE_LSB = 8,
  parameter int CODE_W    = 12,
  parameter logic [CODE_W-1:0] TRAP_CODE = 12'h1d0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opStart,
  input  logic [6:0]        opFlags,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [4:0]        causeOut,
  output logic              opDone,
  output logic              resultWrEn,
  output logic              qnanSel,
  output logic              trapReq,
  output logic [CODE_W-1:0] trapCode
);
  fpxStrobes_t strobes;
  causeVec_t   enables;
  causeVec_t   causeQ;

  fpx_trap_ctrl u_ctrl (
    .opStart (opStart),
    .opFlags (opFlags),
    .regWrEn (regWrEn),
    .enables (enables),
    .strobes (strobes)
  );

  fpx_trap_datapath #(
    .DATA_W(DATA_W), .EN_LSB(EN_LSB), .CAUSE_LSB(CAUSE_LSB),
    .CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regWrData  (regWrData),
    .enables    (enables),
    .causeQ     (causeQ),
    .regRdData  (regRdData),
    .opDone     (opDone),
    .resultWrEn (resultWrEn),
    .qnanSel    (qnanSel),
    .trapReq    (trapReq),
    .trapCode   (trapCode)
  );

  assign causeOut = causeQ;
endmodule

// File: rtl/fpx_trap_checker.sv
module fpx_trap_checker (
  input logic        clk,
  input logic        rstN,
  input logic        opStart,
  input logic [6:0]  opFlags,
  input logic        regWrEn,
  input logic [15:0] regRdData,
  input logic [4:0]  causeOut,
  input logic        opDone,
  input logic        resultWrEn,
  input logic        qnanSel,
  input logic        trapReq,
  input logic [11:0] trapCode
);
  AST_PULSE_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> opDone); // R3
  AST_CLEAN_OP: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && opFlags == 7'd0) |=> (causeOut == 5'd0 && resultWrEn)); // R3
  AST_SINGLE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> $onehot0(causeOut)); // R7
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    resultWrEn |-> (causeOut == 5'd0)); // R10
  AST_QNAN_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    qnanSel |-> resultWrEn); // R5
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> (trapReq == (causeOut != 5'd0))); // R11
  AST_TRAP_CODE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (trapCode == 12'h1d0)); // R11
  AST_OVF_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && !regWrEn && opFlags[6:5] == 2'b00 && opFlags[4] && regRdData[2] && !regRdData[3])
      |=> causeOut == 5'b00100); // R7
endmodule

bind fpx_trap_unit fpx_trap_checker u_fpx_trap_checker (
  .clk(clk), .rstN(rstN), .opStart(opStart), .opFlags(opFlags),
  .regWrEn(regWrEn), .regRdData(regRdData), .causeOut(causeOut),
  .opDone(opDone), .resultWrEn(resultWrEn), .qnanSel(qnanSel),
  .trapReq(trapReq), .trapCode(trapCode)
);

// File: tb/fpx_trap_unit_bench.sv
module fpx_trap_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opStart = 1'b0;
  logic [6:0]  opFlags = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [4:0]  causeOut;
  logic        opDone, resultWrEn, qnanSel, trapReq;
  logic [11:0] trapCode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fpx_trap_unit u_fpx_trap_unit (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opFlags(opFlags),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .causeOut(causeOut), .opDone(opDone), .resultWrEn(resultWrEn),
    .qnanSel(qnanSel), .trapReq(trapReq), .trapCode(trapCode)
  );

  // behavioural reference model
  logic [4:0] mEn, mCause;
  logic       mDone, mWr, mQ, mTrap;

  function automatic logic [4:0] decide(input logic [6:0] f, input logic [4:0] en);
    if (f[6]) return en[4] ? 5'b10000 : 5'b00000;
    if (f[5] && en[3]) return 5'b01000;
    if (f[4] && en[2]) return 5'b00100;
    if ((f[3] || f[2]) && en[1]) return 5'b00010;
    if ((f[1] || f[0]) && en[0]) return 5'b00001;
    return 5'b00000;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn <= 0; mCause <= 0; mDone <= 0; mWr <= 0; mQ <= 0; mTrap <= 0;
    end else begin
      logic [4:0] c;
      c = decide(opFlags, mEn);
      mDone <= opStart;
      mWr   <= opStart && (c == 0);
      mQ    <= opStart && opFlags[6] && !mEn[4];
      mTrap <= opStart && (c != 0);
      if (regWrEn) mEn <= regWrData[4:0];
      if (opStart) mCause <= c;
      else if (regWrEn) mCause <= regWrData[12:8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 model regRdData", 32'(regRdData), 32'({3'b0, mCause, 3'b0, mEn}));
      chk("R3 model opDone", 32'(opDone), 32'(mDone));
      chk("R10 model resultWrEn", 32'(resultWrEn), 32'(mWr));
      chk("R5 model qnanSel", 32'(qnanSel), 32'(mQ));
      chk("R11 model trapReq", 32'(trapReq), 32'(mTrap));
      if (mTrap) chk("R11 model trapCode", 32'(trapCode), 32'h1d0);
    end
  end

  task automatic regWrite(input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // drive one op at a negedge, check outputs at the following negedge
  task automatic runOp(input logic [6:0] f, input logic [4:0] expCause,
                       input logic expWr, input logic expQ, input string tag);
    @(negedge clk);
    opStart = 1'b1; opFlags = f;
    @(negedge clk);
    opStart = 1'b0; opFlags = '0;
    chk({tag, " cause"}, 32'(causeOut), 32'(expCause));
    chk({tag, " resultWrEn"}, 32'(resultWrEn), 32'(expWr));
    chk({tag, " qnanSel"}, 32'(qnanSel), 32'(expQ));
    chk({tag, " trapReq"}, 32'(trapReq), 32'(expCause != 0));
    chk({tag, " opDone"}, 32'(opDone), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset regRdData", 32'(regRdData), 32'h0);
    chk("R1 reset pulses", 32'({opDone, resultWrEn, qnanSel, trapReq}), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 32'(regRdData), 32'h0);

    regWrite(16'h001F);
    chk("R2 enable write", 32'(regRdData), 32'h001F);
    regWrite(16'hFA05);
    chk("R2 both fields, unused bits zero", 32'(regRdData), 32'h1A05);
    regWrite(16'h001F);

    runOp(7'b0000000, 5'b00000, 1, 0, "R3 clean op clears");
    runOp(7'b1010010, 5'b10000, 0, 0, "R4 invalid enabled");
    chk("R11 trap code", 32'(trapCode), 32'h1d0);
    runOp(7'b0111111, 5'b01000, 0, 0, "R6 divide by zero");
    runOp(7'b0011011, 5'b00100, 0, 0, "R7 overflow priority");
    runOp(7'b0001010, 5'b00010, 0, 0, "R8 underflow");
    runOp(7'b0000100, 5'b00010, 0, 0, "R8 denormal");
    runOp(7'b0000010, 5'b00001, 0, 0, "R9 inexact");
    runOp(7'b0000001, 5'b00001, 0, 0, "R9 rounded");
    runOp(7'b0000000, 5'b00000, 1, 0, "R11 no cause no trap");

    regWrite(16'h000F);
    runOp(7'b1011111, 5'b00000, 1, 1, "R5 invalid disabled writes qnan");

    regWrite(16'h000B);
    runOp(7'b0011000, 5'b00010, 0, 0, "R8 overflow disabled falls to underflow");
    regWrite(16'h0009);
    runOp(7'b0011011, 5'b00001, 0, 0, "R9 falls to inexact");

    regWrite(16'h0000);
    runOp(7'b0111111, 5'b00000, 1, 0, "R10 all enables clear");

    // R12: start and write together
    @(negedge clk);
    opStart = 1'b1; opFlags = 7'b0010000; regWrEn = 1'b1; regWrData = 16'h1F04;
    @(negedge clk);
    opStart = 1'b0; opFlags = '0; regWrEn = 1'b0;
    chk("R12 op uses old enables", 32'(causeOut), 32'h0);
    chk("R12 new enables, op cause", 32'(regRdData), 32'h0004);
    runOp(7'b0010000, 5'b00100, 0, 0, "R12 new enables take effect");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule